// File: doc/BRIEF.md
# Branch History Stack

This block keeps a short, rolling record of the most recent control-flow changes a core has taken. These are taken branches, interrupts and exceptions. Each record pairs the address the flow left with the address it went to. The records sit in a small circular register file. A pointer always names the slot that holds the newest record, so software reads the pointer first and then walks backwards through the slots.

Recording runs only while an enable bit is set, and software writes that bit. A debug-exception input freezes the history: it clears the enable bit in hardware, so the records in place describe the path that led up to the debug event. A separate register pair keeps the addresses of the most recent recorded exception or interrupt. The exception pair is not overwritten by the ordinary branches that follow, because only recorded events flagged as exceptions update it.

A single combinational read port returns any slot, the pointer, or the exception pair. The read port always shows the registered state.

Top module: `branch_history_stack`

## Requirements
- R1: After reset the pointer is 0, every slot and the exception pair read as zero, and the enable bit is 0.
- R2: A slot holds the destination address in bits 63..32 and the source address in bits 31..0.
- R3: An event is recorded when `evt_valid` is 1, the enable bit is 1 and `dbg_freeze` is 0. On a recorded event the pointer first advances by one modulo 8, and the record is then written into the slot the new pointer names.
- R4: While the enable bit is 0, events change neither the pointer nor any slot.
- R5: The pointer wraps from 7 to 0. The ninth record after a wrap point overwrites the oldest slot.
- R6: `dbg_freeze` clears the enable bit from the next cycle on. An event in the same cycle as `dbg_freeze` is not recorded. Recording stays off until software writes 1 to the enable bit again.
- R7: When `cfg_we` and `dbg_freeze` are both 1 in the same cycle, `dbg_freeze` wins and the enable bit becomes 0.
- R8: The exception pair takes `{evt_to, evt_from}` only on a recorded event with `evt_is_exc` = 1, and otherwise holds its value.
- R9: `rd_kind` selects what the read port returns: 0 returns the slot at `rd_idx`, 1 returns the pointer in bits 2..0 with zeros above, 2 returns the exception pair as {to, from}, and 3 returns zero.
- R10: A read in the same cycle as a recorded event returns the value from before that event.
- R11: `rec_en` shows the current enable bit. A write with `cfg_we` = 1 loads `cfg_en` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | Value written to the enable bit |
| rec_en | output | 1 | Current enable bit |
| evt_valid | input | 1 | A taken branch, interrupt or exception is presented |
| evt_from | input | 32 | Source address of the event |
| evt_to | input | 32 | Destination address of the event |
| evt_is_exc | input | 1 | The event is an interrupt or exception |
| dbg_freeze | input | 1 | Debug exception raised; freezes the history |
| rd_kind | input | 2 | Read select: 0 slot, 1 pointer, 2 exception pair, 3 none |
| rd_idx | input | 3 | Slot index for a slot read |
| rd_data | output | 64 | Read data |

## Verification
The bench builds the block with its default parameters: 8 slots and 32-bit addresses. With that depth, the pointer wraps after every eight records. The random run therefore crosses the 7-to-0 boundary and overwrites old slots hundreds of times. It also lands freeze pulses, enable writes and reads on the same cycles as events, often enough to cover the priority cases and the read-before-update case many times over.

// File: rtl/bhs_pkg.sv
package bhs_pkg;

    typedef enum logic [1:0] {
        RD_SLOT = 2'd0,
        RD_PTR  = 2'd1,
        RD_EXC  = 2'd2,
        RD_NONE = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/bhs_ctrl.sv
module bhs_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic             evt_valid,
    input  logic             dbg_freeze,
    output logic             en_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] slot_o,
    output logic             rec_o
);

    typedef struct packed {
        logic             en;
        logic [PTR_W-1:0] ptr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [PTR_W-1:0] ptr_inc;

    always_comb begin
        st_d    = st_q;
        ptr_inc = (st_q.ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.ptr + 1'b1;
        rec_o   = evt_valid && st_q.en && !dbg_freeze;
        if (rec_o) begin
            st_d.ptr = ptr_inc;
        end
        if (dbg_freeze) begin
            st_d.en = 1'b0;
        end else if (cfg_we) begin
            st_d.en = cfg_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign ptr_o  = st_q.ptr;
    assign slot_o = ptr_inc;

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_o |=> ptr_o == (($past(ptr_o) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr_o) + 1'b1)); // R3
    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_o |=> $stable(ptr_o)); // R4
    AST_FREEZE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_freeze |=> !en_o); // R6
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_freeze && !cfg_we) |=> $stable(en_o)); // R11

endmodule

// File: rtl/bhs_slot_file.sv
module bhs_slot_file #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REC_W = 2 * ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PTR_W-1:0]            wr_slot,
    input  logic [ADDR_W-1:0]           wr_from,
    input  logic [ADDR_W-1:0]           wr_to,
    input  logic                        wr_exc,
    output logic [DEPTH-1:0][REC_W-1:0] slots_o,
    output logic [REC_W-1:0]            exc_o
);

    typedef struct packed {
        logic [DEPTH-1:0][REC_W-1:0] slot;
        logic [REC_W-1:0]            exc;
    } file_t;

    file_t file_d, file_q;
    logic [REC_W-1:0] rec_word;
    logic [DEPTH-1:0] hit;

    assign rec_word = {wr_to, wr_from};

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_slot == PTR_W'(g));
    end

    always_comb begin
        file_d = file_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) begin
                file_d.slot[i] = rec_word;
            end
        end
        if (wr_en && wr_exc) begin
            file_d.exc = rec_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            file_q <= '0;
        end else begin
            file_q <= file_d;
        end
    end

    assign slots_o = file_q.slot;
    assign exc_o   = file_q.exc;

    AST_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slots_o[$past(wr_slot)] == {$past(wr_to), $past(wr_from)}); // R2
    AST_SLOTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slots_o)); // R4
    AST_EXC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_exc) |=> $stable(exc_o)); // R8
    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R3

endmodule

// File: rtl/bhs_read_mux.sv
module bhs_read_mux
    import bhs_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REC_W = 2 * ADDR_W
) (
    input  logic [1:0]                  kind,
    input  logic [PTR_W-1:0]            idx,
    input  logic [DEPTH-1:0][REC_W-1:0] slots,
    input  logic [PTR_W-1:0]            ptr,
    input  logic [REC_W-1:0]            exc,
    output logic [REC_W-1:0]            data
);

    rd_kind_e sel;

    always_comb begin
        sel = rd_kind_e'(kind);
        unique case (sel)
            RD_SLOT: data = slots[idx];
            RD_PTR:  data = {{(REC_W - PTR_W){1'b0}}, ptr};
            RD_EXC:  data = exc;
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/branch_history_stack.sv
module branch_history_stack #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REC_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_en,
    output logic              rec_en,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_from,
    input  logic [ADDR_W-1:0] evt_to,
    input  logic              evt_is_exc,
    input  logic              dbg_freeze,
    input  logic [1:0]        rd_kind,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [REC_W-1:0]  rd_data
);

    logic                        rec;
    logic [PTR_W-1:0]            ptr_q;
    logic [PTR_W-1:0]            slot_nxt;
    logic [DEPTH-1:0][REC_W-1:0] slots_q;
    logic [REC_W-1:0]            exc_q;

    bhs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_en     (cfg_en),
        .evt_valid  (evt_valid),
        .dbg_freeze (dbg_freeze),
        .en_o       (rec_en),
        .ptr_o      (ptr_q),
        .slot_o     (slot_nxt),
        .rec_o      (rec)
    );

    bhs_slot_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rec),
        .wr_slot (slot_nxt),
        .wr_from (evt_from),
        .wr_to   (evt_to),
        .wr_exc  (evt_is_exc),
        .slots_o (slots_q),
        .exc_o   (exc_q)
    );

    bhs_read_mux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rmux (
        .kind  (rd_kind),
        .idx   (rd_idx),
        .slots (slots_q),
        .ptr   (ptr_q),
        .exc   (exc_q),
        .data  (rd_data)
    );

    AST_WRITE_AT_NEW_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        rec |=> slots_q[ptr_q] == {$past(evt_to), $past(evt_from)}); // R3
    AST_FROZEN_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_freeze && !rec_en) |=> $stable(ptr_q)); // R6

endmodule

// File: tb/test_branch_history_stack.sv
`timescale 1ns/1ps
module test_branch_history_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0;
    logic        rec_en;
    logic        evt_valid = 1'b0, evt_is_exc = 1'b0, dbg_freeze = 1'b0;
    logic [31:0] evt_from = '0, evt_to = '0;
    logic [1:0]  rd_kind = '0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [63:0] m_slot [8];
    logic [2:0]  m_ptr;
    logic        m_en;
    logic [63:0] m_exc;

    always #10 clk = ~clk;

    branch_history_stack i_branch_history_stack (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .rec_en(rec_en),
        .evt_valid(evt_valid), .evt_from(evt_from), .evt_to(evt_to),
        .evt_is_exc(evt_is_exc), .dbg_freeze(dbg_freeze),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [63:0] exp_read(input logic [1:0] k, input logic [2:0] i);
        case (k)
            2'd0:    return m_slot[i];
            2'd1:    return {61'd0, m_ptr};
            2'd2:    return m_exc;
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] f, input logic [31:0] t,
                        input logic x, input logic frz, input logic we, input logic en,
                        input logic [1:0] k, input logic [2:0] i, input string tag);
        logic rec;
        @(negedge clk);
        evt_valid = v; evt_from = f; evt_to = t; evt_is_exc = x;
        dbg_freeze = frz; cfg_we = we; cfg_en = en; rd_kind = k; rd_idx = i;
        #2;
        chk(tag, rd_data, exp_read(k, i));
        chk("R11", {63'd0, rec_en}, {63'd0, m_en});
        @(posedge clk);
        rec = v && m_en && !frz;
        if (rec) begin
            m_ptr = m_ptr + 3'd1;
            m_slot[m_ptr] = {t, f};
            if (x) m_exc = {t, f};
        end
        if (frz) m_en = 1'b0;
        else if (we) m_en = en;
    endtask

    task automatic rd(input logic [1:0] k, input logic [2:0] i, input string tag);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, k, i, tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) m_slot[i] = '0;
        m_ptr = '0; m_en = 1'b0; m_exc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) rd(2'd0, 3'(i), "R1");
        rd(2'd1, 3'd0, "R1");
        rd(2'd2, 3'd0, "R1");
        rd(2'd3, 3'd5, "R9");

        // R4: events while disabled are ignored
        for (int i = 0; i < 3; i++)
            step(1'b1, 32'h1000 + i, 32'h2000 + i, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, "R4");
        rd(2'd1, 3'd0, "R4");
        rd(2'd0, 3'd1, "R4");
        rd(2'd2, 3'd0, "R4");

        // R11: enable, then R10: read pointer in the recording cycle
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 3'd0, "R11");
        step(1'b1, 32'hAAAA_0001, 32'hBBBB_0001, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, "R10");
        rd(2'd1, 3'd0, "R3");
        rd(2'd0, 3'd1, "R2");
        rd(2'd2, 3'd0, "R8");

        // R5: wrap past slot 7
        for (int i = 0; i < 8; i++)
            step(1'b1, 32'hC000_0000 + i, 32'hD000_0000 + i, 1'b0, 1'b0, 1'b0, 1'b0,
                 2'd0, 3'd1, "R10");
        rd(2'd1, 3'd0, "R5");
        for (int i = 0; i < 8; i++) rd(2'd0, 3'(i), "R5");

        // R8: exception record
        step(1'b1, 32'hE1E1_0000, 32'hF2F2_0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 3'd0, "R10");
        rd(2'd2, 3'd0, "R8");
        step(1'b1, 32'h0000_0111, 32'h0000_0222, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 3'd0, "R8");
        rd(2'd2, 3'd0, "R8");

        // R6: freeze with event in the same cycle
        step(1'b1, 32'h5555_0000, 32'h6666_0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 3'd0, "R6");
        rd(2'd1, 3'd0, "R6");
        rd(2'd2, 3'd0, "R6");
        step(1'b1, 32'h7777_0000, 32'h8888_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, "R6");
        rd(2'd1, 3'd0, "R6");

        // R7: freeze wins over a write in the same cycle
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 3'd0, "R7");
        step(1'b1, 32'h9999_0000, 32'hAAAA_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, "R7");
        rd(2'd1, 3'd0, "R7");
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 3'd0, "R6");
        step(1'b1, 32'h1212_0000, 32'h3434_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, "R6");
        rd(2'd1, 3'd0, "R6");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] k;
            string tg;
            k = 2'($urandom_range(0, 3));
            case (k)
                2'd0: tg = "R2";
                2'd1: tg = "R3";
                2'd2: tg = "R8";
                default: tg = "R9";
            endcase
            step(1'($urandom_range(0, 3) != 0), $urandom, $urandom,
                 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 39) == 0),
                 1'($urandom_range(0, 9) == 0), 1'($urandom_range(0, 4) != 0),
                 k, 3'($urandom_range(0, 7)), tg);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule